// File: doc/BRIEF.md
# Interrupt Status, Enable and Clear Register Set

This block gathers the condition lines of an SPI controller: FIFO fill levels, read-data-present flags, trigger events, transfer completion and bad bus accesses. It presents them to software as a 13-bit status word next to an enable word and a write-one-to-clear word. Most status bits are level-tracking: each one shows its source condition as sampled at the previous clock edge. Software can therefore write a clear and then read the status to sample the live FIFO state. A bit cleared while its source is still high simply reads back as one. Two bits, transfer-complete (bit 9) and illegal access (bit 12), are sticky edge captures. They are set on a rising edge of their source and hold until software clears them.

Each status bit has a small two-state machine, CELL_CLR and CELL_SET. A level cell goes CELL_CLR to CELL_SET when its source is high and CELL_SET to CELL_CLR when its source is low. An edge cell goes CELL_CLR to CELL_SET on a rising edge of its source, and CELL_SET to CELL_CLR on a clear write with no rising edge in the same cycle. The register port has states PORT_IDLE and PORT_RESP. A read request enters or stays in PORT_RESP for the next cycle, which marks valid read data. A cycle with no read request returns the port to PORT_IDLE. The interrupt line is active-high and level: it is the OR of status ANDed with enable, with no register in between.

Top module: `irq_stat_regs`

## Requirements
- R1: A read (req_i=1, we_i=0) is answered the next cycle with rvalid_o=1 and rdata_o. Word address 0 returns the status word. Level bits 0-3, 5-8 and 11 equal their cond_i bit as sampled at the previous clock edge.
- R2: Status bits 9 and 12 are set by a clock edge at which their cond_i bit is 1, having been 0 at the previous edge. They stay set after the source falls.
- R3: A write to word address 2 clears every edge status bit whose wdata_i bit is 1. Bits written 0 are unchanged.
- R4: When a rising edge of an edge bit's source and a clear write of that bit fall on the same clock edge, the bit ends up set.
- R5: Clearing a level bit whose source is still 1 has no lasting effect: the next status read shows the bit as 1.
- R6: Word address 1 is the read/write enable word. It resets to zero. Only implemented bits (mask 0x1BEF) are stored, and the other bits read 0.
- R7: irq_o is 1 exactly when some status bit and its enable bit are both 1. It follows status and enable changes without added delay.
- R8: Status bits 4 and 10 always read 0. Reads of word addresses 2 and 3 return 0. Writes to addresses 0 and 3 change nothing.
- R9: During reset, and immediately after it, status and enable are zero and irq_o and rvalid_o are 0. A source of bit 9 or bit 12 that is already high when reset is released does not set its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 13 | Condition lines, one per status bit |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address: 0 status, 1 enable, 2 clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rvalid_o is 1 |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach is the collision between a clear write and a new rising edge on the same edge bit at the same clock edge. The source must first be brought low, then raised in exactly the cycle in which the clear request is driven. The stimulus does this with a dedicated step that changes the condition line and issues the clear write at the same falling edge, after an earlier pulse has already set the bit. A long random phase then mixes condition toggles with bus traffic, and a behavioural model is compared on every cycle.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    localparam int unsigned REG_STATUS = 0;
    localparam int unsigned REG_ENABLE = 1;
    localparam int unsigned REG_CLEAR  = 2;

    typedef enum logic {
        CELL_CLR = 1'b0,
        CELL_SET = 1'b1
    } cell_st_e;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_st_e;

endpackage

// File: rtl/irqs_cell.sv
module irqs_cell
    import irqs_pkg::*;
#(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic clr_i,
    output logic stat_o
);

    cell_st_e st_q;
    cell_st_e st_d;
    logic     prev_q;
    logic     rise;

    // previous source level; starts high so a source already up at reset
    // release is not taken as an event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= cond_i;
        end
    end

    assign rise = cond_i & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CELL_CLR;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (EDGE) begin : g_edge
            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    CELL_CLR: if (rise)            st_d = CELL_SET;
                    CELL_SET: if (clr_i && !rise)  st_d = CELL_CLR;
                    default:                       st_d = CELL_CLR;
                endcase
            end
        end else begin : g_level
            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    CELL_CLR: if (cond_i)  st_d = CELL_SET;
                    CELL_SET: if (!cond_i) st_d = CELL_CLR;
                    default:               st_d = CELL_CLR;
                endcase
            end
        end
    endgenerate

    assign stat_o = (st_q == CELL_SET);

endmodule

// File: rtl/irqs_regport.sv
module irqs_regport
    import irqs_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned NB        = 13,
    parameter logic [NB-1:0] IMPL_MASK = 13'h1BEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NB-1:0]     stat_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [NB-1:0]     en_o,
    output logic [NB-1:0]     clr_o
);

    localparam int unsigned PAD_W = DATA_W - NB;

    port_st_e          st_q;
    port_st_e          st_d;
    logic              rd_hit;
    logic              wr_hit;
    logic [DATA_W-1:0] rsel;
    logic [DATA_W-1:0] rdata_q;
    logic [NB-1:0]     en_q;

    assign rd_hit = req_i && !we_i;
    assign wr_hit = req_i &&  we_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PORT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PORT_IDLE: st_d = rd_hit ? PORT_RESP : PORT_IDLE;
            PORT_RESP: st_d = rd_hit ? PORT_RESP : PORT_IDLE;
            default:   st_d = PORT_IDLE;
        endcase
    end

    always_comb begin
        rsel = '0;
        if (addr_i == ADDR_W'(REG_STATUS)) begin
            rsel = {{PAD_W{1'b0}}, stat_i};
        end else if (addr_i == ADDR_W'(REG_ENABLE)) begin
            rsel = {{PAD_W{1'b0}}, en_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_hit) begin
            rdata_q <= rsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_hit && addr_i == ADDR_W'(REG_ENABLE)) begin
            en_q <= wdata_i[NB-1:0] & IMPL_MASK;
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_hit && addr_i == ADDR_W'(REG_CLEAR)) begin
            clr_o = wdata_i[NB-1:0];
        end
    end

    assign rvalid_o = (st_q == PORT_RESP);
    assign rdata_o  = rdata_q;
    assign en_o     = en_q;

endmodule

// File: rtl/irq_stat_regs.sv
module irq_stat_regs #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned NB          = 13,
    parameter logic [NB-1:0] IMPL_MASK = 13'h1BEF,
    parameter logic [NB-1:0] EDGE_MASK = 13'h1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     cond_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              irq_o
);

    logic [NB-1:0] stat_w;
    logic [NB-1:0] en_w;
    logic [NB-1:0] clr_w;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bit
            if (IMPL_MASK[b]) begin : g_impl
                irqs_cell #(
                    .EDGE (EDGE_MASK[b])
                ) u_cell (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .cond_i (cond_i[b]),
                    .clr_i  (clr_w[b]),
                    .stat_o (stat_w[b])
                );
            end else begin : g_none
                assign stat_w[b] = 1'b0;
            end
        end
    endgenerate

    irqs_regport #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NB        (NB),
        .IMPL_MASK (IMPL_MASK)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .we_i     (we_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .stat_i   (stat_w),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o),
        .en_o     (en_w),
        .clr_o    (clr_w)
    );

    assign irq_o = |(stat_w & en_w);

endmodule

// File: rtl/irq_stat_regs_chk.sv
module irq_stat_regs_chk #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned NB          = 13,
    parameter logic [NB-1:0] IMPL_MASK = 13'h1BEF,
    parameter logic [NB-1:0] EDGE_MASK = 13'h1200
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NB-1:0]     cond_i,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              rvalid_o,
    input logic              irq_o,
    input logic [NB-1:0]     stat_i,
    input logic [NB-1:0]     en_i
);

    localparam logic [NB-1:0] LVL_MASK = IMPL_MASK & ~EDGE_MASK;

    logic [NB-1:0] seen_q;
    logic          clr_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '1;
        end else begin
            seen_q <= cond_i;
        end
    end

    assign clr_wr = req_i && we_i && (addr_i == ADDR_W'(2));

    // R1: level bits follow the source one edge later
    p_level_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_i & LVL_MASK) == ($past(cond_i) & LVL_MASK)));

    p_rvalid_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i) |=> rvalid_o);

    p_rvalid_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !we_i) |=> !rvalid_o);

    // R7: no interrupt while nothing is enabled
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_chk
            if (EDGE_MASK[b] && IMPL_MASK[b]) begin : g_edge
                p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    (cond_i[b] && !seen_q[b]) |=> stat_i[b]);

                p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (stat_i[b] && !(clr_wr && wdata_i[b])) |=> stat_i[b]);

                p_edge_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr_wr && wdata_i[b] && !(cond_i[b] && !seen_q[b])) |=> !stat_i[b]);

                p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr_wr && wdata_i[b] && cond_i[b] && !seen_q[b]) |=> stat_i[b]);
            end
        end
    endgenerate

endmodule

bind irq_stat_regs irq_stat_regs_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NB        (NB),
    .IMPL_MASK (IMPL_MASK),
    .EDGE_MASK (EDGE_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (cond_i),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rvalid_o (rvalid_o),
    .irq_o    (irq_o),
    .stat_i   (stat_w),
    .en_i     (en_w)
);

// File: tb/tb_irq_stat_regs.sv
module tb_irq_stat_regs;

    localparam int NB = 13;
    localparam int DW = 32;
    localparam logic [NB-1:0] IMPL = 13'h1BEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] cond = '0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_stat_regs dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond),
        .req_i    (req),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .rvalid_o (rvalid),
        .irq_o    (irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [NB-1:0] m_stat, m_en, m_prev, m_clr, m_ns;
    logic [DW-1:0] m_rdata;
    logic          m_rvalid;
    logic [1:0]    m_raddr;
    bit            m_live = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0; m_en = '0; m_prev = '1;
            m_rvalid = 1'b0; m_rdata = '0; m_raddr = '0;
            m_live = 1'b1;
        end else begin
            m_clr = (req && we && addr == 2'd2) ? wdata[NB-1:0] : '0;
            m_rvalid = req && !we;
            if (req && !we) begin
                m_raddr = addr;
                m_rdata = (addr == 2'd0) ? {19'b0, m_stat} :
                          (addr == 2'd1) ? {19'b0, m_en} : '0;
            end
            for (int b = 0; b < NB; b++) begin
                if (!IMPL[b])            m_ns[b] = 1'b0;
                else if (b == 9 || b == 12)
                    m_ns[b] = (cond[b] && !m_prev[b]) || (m_stat[b] && !m_clr[b]);
                else                     m_ns[b] = cond[b];
            end
            m_stat = m_ns;
            if (req && we && addr == 2'd1) m_en = wdata[NB-1:0] & IMPL;
            m_prev = cond;
        end
    end

    always @(negedge clk) begin
        if (m_live && !done) begin
            if (!rst_n) begin
                check("R9 irq in reset", {31'b0, irq}, 32'd0);
                check("R9 rvalid in reset", {31'b0, rvalid}, 32'd0);
            end else begin
                check("R7 irq level", {31'b0, irq}, {31'b0, |(m_stat & m_en)});
                check("R1 rvalid timing", {31'b0, rvalid}, {31'b0, m_rvalid});
                if (m_rvalid) begin
                    if (m_raddr == 2'd0)      check("R1 status read", rdata, m_rdata);
                    else if (m_raddr == 2'd1) check("R6 enable read", rdata, m_rdata);
                    else                      check("R8 empty read", rdata, m_rdata);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); req = 1'b0; d = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] v);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = v;
        @(negedge clk); req = 1'b0; we = 1'b0;
    endtask

    task automatic setc(input logic [NB-1:0] v);
        @(negedge clk); cond = v;
    endtask

    initial begin
        logic [DW-1:0] d;
        cond = 13'h0202;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: bit 9 high across reset release is not an event
        rd(2'd0, d); check("R9 status after reset", d, 32'h0002);
        rd(2'd1, d); check("R9 enable after reset", d, 32'h0);

        // R1 and R8: level pattern, bits 4 and 10 driven but read zero
        setc(13'h0FBD);
        rd(2'd0, d); check("R1 level pattern", d, 32'h09AD);
        check("R8 unimplemented bits", d & 32'h0410, 32'h0);

        // R2: rising edge captured, held after fall
        setc(13'h0000); setc(13'h0200); setc(13'h0000);
        rd(2'd0, d); check("R2 edge held", d, 32'h0200);

        // R3: zero bits leave it, one bit clears it
        wr(2'd2, 32'h0); rd(2'd0, d); check("R3 zero write no effect", d, 32'h0200);
        wr(2'd2, 32'h0200); rd(2'd0, d); check("R3 clear", d, 32'h0);

        // R4: set and clear on the same edge
        setc(13'h0200); setc(13'h0000);
        @(negedge clk); cond = 13'h0200; req = 1'b1; we = 1'b1; addr = 2'd2; wdata = 32'h0200;
        @(negedge clk); req = 1'b0; we = 1'b0; cond = 13'h0000;
        rd(2'd0, d); check("R4 set wins", d, 32'h0200);

        // R5: clear of a live level bit
        wr(2'd2, 32'h1200);
        setc(13'h0002);
        wr(2'd2, 32'h0002);
        rd(2'd0, d); check("R5 live level rereads set", d, 32'h0002);

        // R6: enable storage mask
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R6 enable mask", d, 32'h1BEF);
        wr(2'd1, 32'h0); rd(2'd1, d); check("R6 enable cleared", d, 32'h0);

        // R7: sticky illegal-access drives the line until cleared
        setc(13'h0000);
        wr(2'd1, 32'h1000);
        check("R7 irq idle", {31'b0, irq}, 32'd0);
        setc(13'h1000); setc(13'h0000);
        check("R7 irq raised", {31'b0, irq}, 32'd1);
        @(negedge clk); check("R7 irq held", {31'b0, irq}, 32'd1);
        wr(2'd2, 32'h1000);
        check("R7 irq dropped", {31'b0, irq}, 32'd0);

        // R8: dead addresses
        rd(2'd2, d); check("R8 clear reads zero", d, 32'h0);
        rd(2'd3, d); check("R8 reserved reads zero", d, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R8 enable untouched", d, 32'h1000);
        rd(2'd0, d); check("R8 status untouched", d, 32'h0);

        // random mix, compared against the model each cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cond  = NB'($urandom);
            req   = ($urandom % 3) == 0;
            we    = $urandom % 2;
            addr  = 2'($urandom);
            wdata = $urandom;
        end
        @(negedge clk); req = 1'b0; we = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule